// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Bit Streamer

This block sends a fixed 32-bit identification word out of a serial data pin when the host pulses a dedicated reset line, the way synchronous memory cards answer a reset. The host holds chip select low, raises the reset line and then drops it again. The block then presents the word one bit per serial clock, starting with the least significant bit. It drives the data pin only while the word is being sent, so the pin is high impedance at every other time. The word comes in on a register input, and whatever loads it from storage sits outside this block.

The block runs on a system clock. The serial clock, chip select, reset line and write-busy flag reach it already synchronous to that clock, and it detects serial clock falling edges by sampling. A write cycle that is in progress stops a stream from starting. Raising chip select ends the stream at once and returns the block to standby. A new reset pulse in the middle of a stream starts it again from bit 0. A one-cycle done pulse marks a stream that was sent in full.

Top module: `atr_streamer`

## Requirements
- R1: While rst_ni is low and in the cycle after it is released, sda_oe_o and done_o are 0.
- R2: If atr_rst_i is sampled high while cs_ni is low and wr_busy_i is low, and atr_rst_i is later sampled low with cs_ni still low and wr_busy_i low, then sda_oe_o is 1 from the next cycle and sda_o carries bit 0 of pattern_i as sampled on that cycle.
- R3: While wr_busy_i is high, a pulse on atr_rst_i starts no stream, and sda_oe_o stays 0.
- R4: During a stream, sda_o moves to the next higher pattern bit (least significant bit first) in the cycle after each sampled falling edge of scl_i, which is scl_i going from 1 to 0 between two samples. At all other times it holds its value.
- R5: The falling edge that retires bit 31 makes sda_oe_o go to 0 and makes done_o go to 1 for exactly one cycle, both in the next cycle.
- R6: If cs_ni is sampled high at any point in a stream, the stream is abandoned. sda_oe_o is 0 from the next cycle and done_o is never pulsed for that stream.
- R7: If atr_rst_i is sampled high during a stream, sda_oe_o drops in the next cycle. When atr_rst_i falls, the stream restarts from bit 0.
- R8: Whenever sda_oe_o is 0, sda_o is 0.
- R9: While cs_ni is high, atr_rst_i has no effect and no stream starts.
- R10: The pattern is captured when the stream starts. A change of pattern_i during a stream does not alter the bits that are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock, synchronous to clk_i |
| cs_ni | input | 1 | Active-low chip select |
| atr_rst_i | input | 1 | Answer-to-reset trigger line |
| wr_busy_i | input | 1 | High while a write cycle is in progress |
| pattern_i | input | 32 | Word to be streamed |
| sda_o | output | 1 | Serial data value |
| sda_oe_o | output | 1 | Output enable for the tri-state data pin |
| done_o | output | 1 | One-cycle pulse when a full stream completes |

## Verification
The assertions take it as given that every input is already synchronous to clk_i. They also take it that scl_i holds each level for at least one system clock, so every falling edge is seen as a 1 followed by a 0 on consecutive samples. The stimulus changes inputs only on the falling edge of clk_i. It holds scl_i at each level for two system clocks, and it pulses atr_rst_i for several cycles. In this way every transition falls on a clean sample, and the bench's reference model can follow the stream bit by bit.

// File: rtl/atr_pkg.sv
package atr_pkg;
  typedef enum logic [1:0] {
    ATR_IDLE  = 2'd0,
    ATR_ARMED = 2'd1,
    ATR_SHIFT = 2'd2
  } atr_state_e;
endpackage

// File: rtl/atr_edge_det.sv
module atr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/atr_shift_reg.sv
module atr_shift_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] pattern_i,
  output logic             bit_o
);
  logic [WIDTH-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (load_i)  q_q <= pattern_i;
    else if (shift_i) q_q <= {1'b0, q_q[WIDTH-1:1]};
  end

  assign bit_o = q_q[0];

  // R10
  load_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_q == $past(pattern_i));

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(q_q));
endmodule

// File: rtl/atr_seq_ctrl.sv
module atr_seq_ctrl
  import atr_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic atr_rst_i,
  input  logic wr_busy_i,
  input  logic scl_fall_i,
  output logic load_o,
  output logic shift_o,
  output logic active_o,
  output logic done_o
);
  localparam int unsigned CntW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CntW-1:0] LastIdx = CntW'(WIDTH - 1);

  atr_state_e      state_q, state_d;
  logic [CntW-1:0] cnt_q, cnt_d;
  logic            done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    shift_o = 1'b0;
    unique case (state_q)
      ATR_IDLE: begin
        if (!cs_ni && atr_rst_i && !wr_busy_i) state_d = ATR_ARMED;
      end
      ATR_ARMED: begin
        if (cs_ni || wr_busy_i) begin
          state_d = ATR_IDLE;
        end else if (!atr_rst_i) begin
          state_d = ATR_SHIFT;
          cnt_d   = '0;
          load_o  = 1'b1;
        end
      end
      ATR_SHIFT: begin
        if (cs_ni) begin
          state_d = ATR_IDLE;
        end else if (atr_rst_i) begin
          state_d = ATR_ARMED;
        end else if (scl_fall_i) begin
          if (cnt_q == LastIdx) begin
            state_d = ATR_IDLE;
            done_d  = 1'b1;
          end else begin
            cnt_d   = cnt_q + 1'b1;
            shift_o = 1'b1;
          end
        end
      end
      default: state_d = ATR_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ATR_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign active_o = (state_q == ATR_SHIFT);
  assign done_o   = done_q;

  // R6
  cs_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (state_q == ATR_IDLE) && !done_q);

  // R3
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ATR_SHIFT && wr_busy_i) |=> state_q != ATR_SHIFT);

  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ATR_SHIFT && !cs_ni && atr_rst_i) |=> state_q == ATR_ARMED);

  // R5
  done_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(state_q == ATR_SHIFT && cnt_q == LastIdx && scl_fall_i));

  // R5
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R4
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ATR_SHIFT && !cs_ni && !atr_rst_i && scl_fall_i && cnt_q != LastIdx)
      |=> cnt_q == $past(cnt_q) + 1'b1);

  // R9
  cs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ATR_IDLE && cs_ni) |=> state_q == ATR_IDLE);
endmodule

// File: rtl/atr_streamer.sv
module atr_streamer #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             cs_ni,
  input  logic             atr_rst_i,
  input  logic             wr_busy_i,
  input  logic [WIDTH-1:0] pattern_i,
  output logic             sda_o,
  output logic             sda_oe_o,
  output logic             done_o
);
  logic scl_fall, load, shift, active, bit_val;

  atr_edge_det i_scl_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (scl_i),
    .fall_o (scl_fall)
  );

  atr_seq_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .atr_rst_i  (atr_rst_i),
    .wr_busy_i  (wr_busy_i),
    .scl_fall_i (scl_fall),
    .load_o     (load),
    .shift_o    (shift),
    .active_o   (active),
    .done_o     (done_o)
  );

  atr_shift_reg #(.WIDTH(WIDTH)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .shift_i   (shift),
    .pattern_i (pattern_i),
    .bit_o     (bit_val)
  );

  // keep the pad value quiet when not driving
  assign sda_o    = active & bit_val;
  assign sda_oe_o = active;

  // R8
  quiet_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sda_oe_o |-> !sda_o);

  // R5
  done_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !sda_oe_o);
endmodule

// File: tb/test_atr_streamer.sv
module test_atr_streamer;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b0, cs_n = 1'b1, atr_rst = 1'b0, busy = 1'b0;
  logic [WIDTH-1:0] pattern = '0;
  logic sda, sda_oe, done;

  int checks = 0;
  int errors = 0;
  int done_seen = 0;
  string cur_req = "R1";

  // reference model
  int  m_state = 0;            // 0 standby, 1 waiting for trigger release, 2 sending
  bit  m_bits[$];
  bit  m_done = 0;
  bit  m_scl_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atr_streamer #(.WIDTH(WIDTH)) i_atr_streamer (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .cs_ni(cs_n),
    .atr_rst_i(atr_rst), .wr_busy_i(busy), .pattern_i(pattern),
    .sda_o(sda), .sda_oe_o(sda_oe), .done_o(done)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit fall = m_scl_prev && !scl;
    m_scl_prev = scl;
    m_done = 0;
    case (m_state)
      0: if (!cs_n && atr_rst && !busy) m_state = 1;
      1: begin
        if (cs_n || busy) m_state = 0;
        else if (!atr_rst) begin
          m_state = 2;
          m_bits.delete();
          for (int i = 0; i < WIDTH; i++) m_bits.push_back(pattern[i]);
        end
      end
      default: begin
        if (cs_n) m_state = 0;
        else if (atr_rst) m_state = 1;
        else if (fall) begin
          void'(m_bits.pop_front());
          if (m_bits.size() == 0) begin
            m_state = 0;
            m_done = 1;
          end
        end
      end
    endcase
  endtask

  // inputs set at negedge; one clock; compare at next negedge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(cur_req, "sda_oe", sda_oe, (m_state == 2));
    check(cur_req, "done", done, m_done);
    if (m_state == 2) check(cur_req, "sda", sda, m_bits[0]);
    else check("R8", "sda idle", sda, 0);
    if (done) done_seen++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic pulse_rst(int n);
    atr_rst = 1'b1;
    idle(n);
    atr_rst = 1'b0;
    idle(1);
  endtask

  task automatic scl_bits(int n);
    for (int i = 0; i < n; i++) begin
      scl = 1'b1; idle(2);
      scl = 1'b0; idle(2);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1", "oe in reset", sda_oe, 0);
    check("R1", "done in reset", done, 0);
    rst_n = 1'b1;
    cur_req = "R1";
    idle(2);

    // R2 R4 R5: full stream, pattern A
    cur_req = "R2";
    pattern = 32'hA5C3_0F96;
    cs_n = 1'b0;
    idle(1);
    pulse_rst(3);
    cur_req = "R4";
    scl_bits(31);
    cur_req = "R5";
    done_seen = 0;
    scl_bits(1);
    idle(2);
    check("R5", "done count", done_seen, 1);
    check("R5", "oe after stream", sda_oe, 0);

    // R4 R5: second pattern, alternating
    cur_req = "R4";
    pattern = 32'h5555_AAAA;
    pulse_rst(2);
    scl_bits(WIDTH);
    idle(2);

    // R3: blocked while busy
    cur_req = "R3";
    busy = 1'b1;
    pulse_rst(3);
    scl_bits(3);
    check("R3", "no stream while busy", sda_oe, 0);
    busy = 1'b0;
    idle(2);

    // R6: abort via chip select
    cur_req = "R6";
    pattern = 32'hDEAD_BEEF;
    pulse_rst(2);
    scl_bits(10);
    done_seen = 0;
    cs_n = 1'b1;
    idle(2);
    scl_bits(30);
    check("R6", "no done after abort", done_seen, 0);
    check("R6", "oe after abort", sda_oe, 0);

    // R9: trigger ignored while deselected
    cur_req = "R9";
    pulse_rst(3);
    scl_bits(2);
    check("R9", "no stream when deselected", sda_oe, 0);
    cs_n = 1'b0;
    idle(2);

    // R7: restart mid-stream
    cur_req = "R7";
    pattern = 32'h0123_4567;
    pulse_rst(2);
    scl_bits(12);
    pulse_rst(3);
    check("R7", "restart bit0", sda, pattern[0]);
    scl_bits(WIDTH);
    idle(2);

    // R10: pattern change during stream ignored
    cur_req = "R10";
    pattern = 32'hF0F0_1234;
    pulse_rst(2);
    scl_bits(4);
    pattern = 32'h0F0F_EDCB;
    scl_bits(WIDTH - 4);
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule